// File: doc/BRIEF.md
# Bistable Ring Challenge Evaluation Sequencer

This block runs one challenge-response measurement on an external bistable ring array. A start strobe, taken while the block is idle, stores the challenge and the settling time. The stored challenge goes out on a registered bus at the same time as the ring's reset line is raised. After a fixed number of cycles the reset is dropped, and the challenge stays where it is. The block then counts out the settling window, and only after that takes the ring's single output bit. That bit has passed through a two-flop synchronizer. It is returned together with a one-cycle valid strobe.

The ring can only ever come to rest in one of two states, so the response is always one bit. Each challenge bit selects the configuration of one ring stage. A busy flag covers the whole measurement. Any start strobe that arrives during that time is dropped, and its challenge and settling values are dropped with it.

Top module: `ring_eval_seq`

## Requirements
- R1: After reset, ring_rst_o, busy_o, resp_valid_o and resp_o are 0, and ring_chal_o is all zeros.
- R2: If start_i is high at a clock edge while busy_o is low, then right after that edge ring_rst_o is 1, busy_o is 1 and ring_chal_o equals the challenge_i value sampled at that edge.
- R3: Each evaluation raises ring_rst_o for exactly RST_CYC consecutive cycles (RST_CYC ≥ 1), and busy_o remains 1 when ring_rst_o falls.
- R4: ring_chal_o does not change from the moment ring_rst_o rises until the response is valid.
- R5: resp_valid_o goes high exactly RST_CYC + S + 1 cycles after the accepting start edge and stays high for one cycle only. S is the settle_i value sampled at that edge.
- R6: resp_o presents the ring_resp_i value sampled at the clock edge two edges before the edge that raises resp_valid_o. That is, the value passes through a two-flop synchronizer, and the sample is taken S−1 edges after ring_rst_o falls.
- R7: While busy_o is 1, start_i, challenge_i and settle_i have no effect. ring_chal_o, the reset timing, the valid timing and the response are those of the evaluation already running.
- R8: busy_o stays 1 from the edge that accepts start until the edge that raises resp_valid_o, and it falls at that same edge.
- R9: A start_i given in the cycle where resp_valid_o is high is accepted and begins a new evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; accepted only when idle |
| challenge_i | input | CHAL_W | Challenge, one bit per ring stage |
| settle_i | input | CNT_W | Settling window in cycles (S) |
| ring_rst_o | output | 1 | Reset line to the ring |
| ring_chal_o | output | CHAL_W | Registered challenge bus to the ring |
| ring_resp_i | input | 1 | Asynchronous ring output bit |
| resp_o | output | 1 | Captured response |
| resp_valid_o | output | 1 | One-cycle response valid pulse |
| busy_o | output | 1 | Evaluation in progress |

## Verification
The bench builds the block with CHAL_W=64, RST_CYC=3 and CNT_W=6. With these values the full default challenge width is exercised, and a short reset pulse keeps each run brief. The narrow counter also brings the largest settling value, 63, within reach. The ring stand-in returns an inverted answer until a set number of cycles has passed since reset release. Settling values one below and exactly at the threshold therefore expose the synchronizer's two-cycle sampling point. Spurious starts issued during the pulse and during settling, and a start given in the valid cycle, exercise the ignore rule and the back-to-back rule.

// File: rtl/ring_eval_pkg.sv
package ring_eval_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PULSE  = 2'd1,
        ST_SETTLE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ring_eval_timer.sv
module ring_eval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = load_val_i;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign zero_o = (tmr_q.cnt == '0);

    // Counting down one step per cycle sets the window lengths
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !zero_o) |=> (tmr_q.cnt == $past(tmr_q.cnt) - 1'b1));

    assert_load_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (tmr_q.cnt == $past(load_val_i)));
endmodule

// File: rtl/ring_resp_sync.sv
module ring_resp_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = async_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.s2;
endmodule

// File: rtl/ring_eval_ctrl.sv
module ring_eval_ctrl
    import ring_eval_pkg::*;
#(
    parameter int CHAL_W  = 64,
    parameter int CNT_W   = 16,
    parameter int RST_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CHAL_W-1:0] challenge_i,
    input  logic [CNT_W-1:0]  settle_i,
    input  logic              timer_zero_i,
    input  logic              sync_resp_i,
    output logic              timer_load_o,
    output logic [CNT_W-1:0]  timer_val_o,
    output logic              ring_rst_o,
    output logic [CHAL_W-1:0] ring_chal_o,
    output logic              resp_o,
    output logic              resp_valid_o,
    output logic              busy_o
);
    localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(RST_CYC - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CHAL_W-1:0] chal;
        logic [CNT_W-1:0]  settle;
        logic              resp;
        logic              valid;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.valid = 1'b0;
        timer_load_o = 1'b0;
        timer_val_o  = RST_LOAD;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctrl_d.state  = ST_PULSE;
                    ctrl_d.chal   = challenge_i;
                    ctrl_d.settle = settle_i;
                    timer_load_o  = 1'b1;
                    timer_val_o   = RST_LOAD;
                end
            end
            ST_PULSE: begin
                if (timer_zero_i) begin
                    ctrl_d.state = ST_SETTLE;
                    timer_load_o = 1'b1;
                    timer_val_o  = ctrl_q.settle;
                end
            end
            ST_SETTLE: begin
                if (timer_zero_i) begin
                    ctrl_d.state = ST_IDLE;
                    ctrl_d.resp  = sync_resp_i;
                    ctrl_d.valid = 1'b1;
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '{state: ST_IDLE, default: '0};
        else        ctrl_q <= ctrl_d;
    end

    assign ring_rst_o   = (ctrl_q.state == ST_PULSE);
    assign ring_chal_o  = ctrl_q.chal;
    assign resp_o       = ctrl_q.resp;
    assign resp_valid_o = ctrl_q.valid;
    assign busy_o       = (ctrl_q.state != ST_IDLE);

    assert_rst_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ring_rst_o) |-> ($past(start_i) && !$past(busy_o)));

    assert_rst_drop_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ring_rst_o) |-> busy_o);

    assert_chal_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(ring_chal_o));

    assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o |=> !resp_valid_o);

    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o && !ring_rst_o && !timer_zero_i) |=> !ring_rst_o);

    assert_busy_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_valid_o) |-> $fell(busy_o));
endmodule

// File: rtl/ring_eval_seq.sv
module ring_eval_seq #(
    parameter int CHAL_W  = 64,
    parameter int CNT_W   = 16,
    parameter int RST_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CHAL_W-1:0] challenge_i,
    input  logic [CNT_W-1:0]  settle_i,
    output logic              ring_rst_o,
    output logic [CHAL_W-1:0] ring_chal_o,
    input  logic              ring_resp_i,
    output logic              resp_o,
    output logic              resp_valid_o,
    output logic              busy_o
);
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_zero;
    logic             sync_resp;

    ring_eval_timer #(.CNT_W(CNT_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (timer_load),
        .load_val_i (timer_val),
        .zero_o     (timer_zero)
    );

    ring_resp_sync sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ring_resp_i),
        .sync_o  (sync_resp)
    );

    ring_eval_ctrl #(
        .CHAL_W  (CHAL_W),
        .CNT_W   (CNT_W),
        .RST_CYC (RST_CYC)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .challenge_i  (challenge_i),
        .settle_i     (settle_i),
        .timer_zero_i (timer_zero),
        .sync_resp_i  (sync_resp),
        .timer_load_o (timer_load),
        .timer_val_o  (timer_val),
        .ring_rst_o   (ring_rst_o),
        .ring_chal_o  (ring_chal_o),
        .resp_o       (resp_o),
        .resp_valid_o (resp_valid_o),
        .busy_o       (busy_o)
    );
endmodule

// File: tb/ring_eval_seq_tb.sv
module ring_eval_seq_tb_top;
    localparam int CHAL_W  = 64;
    localparam int CNT_W   = 6;
    localparam int RST_CYC = 3;
    localparam int SETTLE_D = 5;   // stand-in ring needs this many cycles after release
    localparam logic [CHAL_W-1:0] KEY = 64'hA5C3_0F96_3C5A_E187;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [CHAL_W-1:0] challenge_i = '0;
    logic [CNT_W-1:0]  settle_i = '0;
    logic              ring_rst_o;
    logic [CHAL_W-1:0] ring_chal_o;
    logic              ring_resp_i;
    logic              resp_o, resp_valid_o, busy_o;

    int checks = 0;
    int failures = 0;
    int rel_cnt = 0;

    always #2.5 clk = ~clk;

    ring_eval_seq #(.CHAL_W(CHAL_W), .CNT_W(CNT_W), .RST_CYC(RST_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .challenge_i(challenge_i),
        .settle_i(settle_i), .ring_rst_o(ring_rst_o), .ring_chal_o(ring_chal_o),
        .ring_resp_i(ring_resp_i), .resp_o(resp_o), .resp_valid_o(resp_valid_o),
        .busy_o(busy_o)
    );

    // Behavioural ring: wrong (inverted) answer until SETTLE_D cycles after release
    always @(posedge clk) begin
        if (ring_rst_o) rel_cnt <= 0;
        else if (rel_cnt < 1000) rel_cnt <= rel_cnt + 1;
    end
    assign ring_resp_i = (^(ring_chal_o & KEY)) ^ (rel_cnt < SETTLE_D);

    function automatic logic ideal(input logic [CHAL_W-1:0] c);
        return ^(c & KEY);
    endfunction

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Call at a negedge. Returns at the negedge where valid is seen.
    task automatic run_eval(input logic [CHAL_W-1:0] c, input int s, input bit inject,
                            output logic resp_got);
        int n;
        int rst_hi;
        bit seen;
        start_i = 1'b1; challenge_i = c; settle_i = CNT_W'(s);
        @(negedge clk);
        start_i = 1'b0; challenge_i = ~c; settle_i = '0;
        chk(ring_rst_o == 1'b1, "R2 ring_rst_o", ring_rst_o, 1);
        chk(busy_o == 1'b1, "R2 busy_o", busy_o, 1);
        chk(ring_chal_o == c, "R2 ring_chal_o", ring_chal_o, c);
        rst_hi = 1; seen = 0; n = 0; resp_got = 1'b0;
        while (!seen && n < 200) begin
            if (inject && (n == 1 || n == RST_CYC + 1)) begin
                start_i = 1'b1; challenge_i = c ^ 64'hFFFF; settle_i = '1;
            end
            @(negedge clk);
            start_i = 1'b0;
            n++;
            if (resp_valid_o) begin
                seen = 1;
                resp_got = resp_o;
            end else begin
                if (ring_rst_o) rst_hi++;
                if (!busy_o || ring_chal_o != c) begin
                    chk(0, "R4/R7 busy and challenge held", ring_chal_o, c);
                end
            end
        end
        chk(n == RST_CYC + s + 1, "R5 valid latency", n, RST_CYC + s + 1);
        chk(rst_hi == RST_CYC, "R3 reset width", rst_hi, RST_CYC);
        chk(busy_o == 1'b0, "R8 busy low at valid", busy_o, 0);
    endtask

    function automatic logic expect_resp(input logic [CHAL_W-1:0] c, input int s);
        // R6: sample taken s-2 cycles after release count starts
        return ideal(c) ^ ((s - 2) < SETTLE_D);
    endfunction

    task automatic test_reset();
        chk(ring_rst_o == 1'b0, "R1 ring_rst_o", ring_rst_o, 0);
        chk(busy_o == 1'b0, "R1 busy_o", busy_o, 0);
        chk(resp_valid_o == 1'b0, "R1 resp_valid_o", resp_valid_o, 0);
        chk(resp_o == 1'b0, "R1 resp_o", resp_o, 0);
        chk(ring_chal_o == '0, "R1 ring_chal_o", ring_chal_o, 0);
    endtask

    task automatic test_basic(input logic [CHAL_W-1:0] c, input int s);
        logic r;
        run_eval(c, s, 0, r);
        chk(r == expect_resp(c, s), "R6 response", r, expect_resp(c, s));
        @(negedge clk);
        chk(resp_valid_o == 1'b0, "R5 valid single cycle", resp_valid_o, 0);
    endtask

    task automatic test_ignore();
        logic r;
        logic [CHAL_W-1:0] c = 64'h0123_4567_89AB_CDEF;
        run_eval(c, 10, 1, r);
        chk(r == expect_resp(c, 10), "R7 response unaffected", r, expect_resp(c, 10));
        @(negedge clk);
        chk(busy_o == 1'b0, "R7 no restart after spurious start", busy_o, 0);
    endtask

    task automatic test_back_to_back();
        logic r;
        logic [CHAL_W-1:0] c1 = 64'hDEAD_BEEF_0000_FFFF;
        logic [CHAL_W-1:0] c2 = 64'h1111_2222_4444_8888;
        run_eval(c1, 8, 0, r);
        chk(r == expect_resp(c1, 8), "R9 first response", r, expect_resp(c1, 8));
        run_eval(c2, 9, 0, r);
        chk(r == expect_resp(c2, 9), "R9 second response", r, expect_resp(c2, 9));
        @(negedge clk);
    endtask

    initial begin
        #(5 * 20000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_basic(64'hFFFF_FFFF_FFFF_FFFF, 12);
        test_basic(64'h0000_0000_0000_0001, 20);
        test_basic(64'h8000_0000_0000_0000, SETTLE_D + 1);  // one short: inverted
        test_basic(64'h8000_0000_0000_0000, SETTLE_D + 2);  // exactly enough
        test_basic(64'h5555_AAAA_3333_CCCC, 63);            // largest settle
        test_ignore();
        test_back_to_back();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule